// File: doc/BRIEF.md
# Conversion Ready Status Controller

This block follows a sampling converter and keeps the "new result" flag that a bus master reads in the status byte. The flag has inverted sense. Low means that a fresh result is waiting and has not been read. High means that there is nothing new. The bus logic sends three kinds of event into the block:

- configuration writes, each carrying a start bit and a mode bit;
- read-complete pulses, sent once the master has taken the result bytes;
- conversion-complete pulses with data, sent by the converter model.

The block drives three outputs: a conversion-start request, the result register and the status byte.

There are two modes. In continuous mode the block asks for a new conversion one cycle after each completion, and a read raises the flag again. In one-shot mode a conversion starts only on a configuration write with the start bit set. A one-shot result that has been read keeps the flag low until the next such write. Gain, rate and channel fields are not interpreted. They are stored and returned in the status byte.

Encodings used throughout:

- Configuration byte: bit 7 is start, bit 4 is mode (1 = continuous, 0 = one-shot). Bits 6:0 are stored as written.
- Status byte: bit 7 is the flag, and bits 6:0 are the stored configuration bits.

Top module: `cnv_ready_ctrl`

## Requirements
- R1: A synchronous reset sets continuous mode with stored configuration bits 6:0 = 0x10, so the status byte reads 0x90. The result register reads 0 and conv_start is low.
- R2: A conv_done pulse puts conv_data into the result register on the next cycle. This happens whether or not the previous result was read.
- R3: A conv_done pulse drives the flag (status bit 7) low on the next cycle. This holds even when rd_done or a configuration write arrives in the same cycle.
- R4: In continuous mode (stored bit 4 = 1), rd_done without conv_done drives the flag high on the next cycle.
- R5: In one-shot mode (stored bit 4 = 0), rd_done does not change the flag. A flag that is low stays low until a one-shot start write.
- R6: A configuration write with bit 4 = 0 and bit 7 = 1 starts a one-shot conversion. The flag goes high and conv_start pulses for one cycle on the next cycle. The flag stays high until conv_done.
- R7: A configuration write with bit 4 = 0 and bit 7 = 0 starts nothing. conv_start stays low and the flag keeps its value.
- R8: A configuration write with bit 4 = 1 raises conv_start on the next cycle, whatever the value of bit 7. By itself it leaves the flag unchanged.
- R9: In continuous mode each conv_done raises conv_start on the next cycle. In one-shot mode conv_done raises no request.
- R10: Status bits 6:0 show configuration bits 6:0 from the most recent write, from the cycle after that write. A write is accepted in any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration byte (bit 7 start, bit 4 mode) |
| conv_done | input | 1 | Conversion-complete pulse |
| conv_data | input | RES_W (18) | Result carried with conv_done |
| rd_done | input | 1 | Master has consumed the result bytes |
| conv_start | output | 1 | Conversion-start request, registered |
| result | output | RES_W (18) | Output result register |
| status | output | 8 | {flag, stored configuration bits 6:0} |

## Verification
A completion and a read-complete can arrive in the same cycle, and the block's answer to that case decides whether the master misses a result. The vector table drives conv_done and rd_done together in continuous mode and expects status bit 7 low on the next cycle, with the new value in the result register. A second collision drives conv_done together with a one-shot start write. The bench then expects the flag low, the new result stored and a start request caused by the previous continuous mode.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  localparam int CFG_W    = 8;
  localparam int GO_BIT   = 7;
  localparam int MODE_BIT = 4;
  localparam int KEEP_W   = CFG_W - 1;
  localparam logic [KEEP_W-1:0] CFG_RST = 7'h10;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_CONT    = 1'b1
  } cnv_mode_e;
endpackage

// File: rtl/cnv_cfg_reg.sv
module cnv_cfg_reg
  import cnv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              conv_done,
  output logic [KEEP_W-1:0] cfg_q,
  output cnv_mode_e         mode,
  output logic              oneshot_go,
  output logic              conv_start
);
  logic start_req;

  assign mode       = cnv_mode_e'(cfg_q[MODE_BIT]);
  assign oneshot_go = cfg_wr && !cfg_data[MODE_BIT] && cfg_data[GO_BIT];
  assign start_req  = cfg_wr && (cfg_data[MODE_BIT] || cfg_data[GO_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= CFG_RST;
      conv_start <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_data[KEEP_W-1:0];
      conv_start <= start_req || (conv_done && mode == MODE_CONT);
    end
  end

  // R7: idle one-shot write with no completion gives no request
  a_r7_no_start: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_data[GO_BIT] && !cfg_data[MODE_BIT] && !conv_done) |=> !conv_start);
  // R8: continuous write always requests
  a_r8_cont_write_starts: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_data[MODE_BIT]) |=> conv_start);
  // R10: stored bits follow the write
  a_r10_cfg_stored: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> cfg_q == $past(cfg_data[KEEP_W-1:0]));
endmodule

// File: rtl/cnv_flag_fsm.sv
module cnv_flag_fsm
  import cnv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cnv_mode_e mode,
  input  logic      oneshot_go,
  input  logic      conv_done,
  input  logic      rd_done,
  output logic      flag
);
  always_ff @(posedge clk) begin
    if (rst)                                  flag <= 1'b1;
    else if (conv_done)                       flag <= 1'b0;
    else if (oneshot_go)                      flag <= 1'b1;
    else if (rd_done && mode == MODE_CONT)    flag <= 1'b1;
  end

  // R3: a completion always leaves an unread result
  a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !flag);
  // R4: continuous read raises the flag
  a_r4_cont_read: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !conv_done && mode == MODE_CONT) |=> flag);
  // R5: one-shot read keeps a low flag low
  a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !conv_done && !oneshot_go && mode == MODE_ONESHOT && !flag) |=> !flag);
  // R6: one-shot start raises the flag
  a_r6_go_raises: assert property (@(posedge clk) disable iff (rst)
    (oneshot_go && !conv_done) |=> flag);
endmodule

// File: rtl/cnv_result_reg.sv
module cnv_result_reg #(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [RES_W-1:0] result
);
  always_ff @(posedge clk) begin
    if (rst)            result <= '0;
    else if (conv_done) result <= conv_data;
  end

  // R2: every completion overwrites the register
  a_r2_overwrite: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> result == $past(conv_data));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(result));
endmodule

// File: rtl/cnv_ready_ctrl.sv
module cnv_ready_ctrl
  import cnv_pkg::*;
#(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_data,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             rd_done,
  output logic             conv_start,
  output logic [RES_W-1:0] result,
  output logic [7:0]       status
);
  logic [KEEP_W-1:0] cfg_q;
  cnv_mode_e         mode;
  logic              oneshot_go;
  logic              flag;

  cnv_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .conv_done(conv_done), .cfg_q(cfg_q), .mode(mode),
    .oneshot_go(oneshot_go), .conv_start(conv_start)
  );

  cnv_flag_fsm u_flag (
    .clk(clk), .rst(rst), .mode(mode), .oneshot_go(oneshot_go),
    .conv_done(conv_done), .rd_done(rd_done), .flag(flag)
  );

  cnv_result_reg #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .conv_done(conv_done),
    .conv_data(conv_data), .result(result)
  );

  assign status = {flag, cfg_q};

  // R9: continuous completion requests the next conversion
  a_r9_cont_restart: assert property (@(posedge clk) disable iff (rst)
    (conv_done && mode == MODE_CONT) |=> conv_start);
  // R9: one-shot completion without a write gives no request
  a_r9_oneshot_quiet: assert property (@(posedge clk) disable iff (rst)
    (conv_done && mode == MODE_ONESHOT && !cfg_wr) |=> !conv_start);
  // R1: the cycle after reset shows the reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (status == 8'h90 && result == '0 && !conv_start));
endmodule

// File: tb/sim_cnv_ready_ctrl.sv
module sim_cnv_ready_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 18;
  localparam int NV = 18;
  // {cfg_wr, cfg_data, conv_done, conv_data, rd_done, exp_status, exp_start, exp_result}
  localparam int VW = 1 + 8 + 1 + RES_W + 1 + 8 + 1 + RES_W;

  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 18'h00000, 1'b0, 8'h90, 1'b0, 18'h00000}, // idle
    {1'b1, 8'h10, 1'b0, 18'h00000, 1'b0, 8'h90, 1'b1, 18'h00000}, // R8 cont write
    {1'b0, 8'h00, 1'b1, 18'h00123, 1'b0, 8'h10, 1'b1, 18'h00123}, // R2 R3 R9
    {1'b0, 8'h00, 1'b0, 18'h00000, 1'b0, 8'h10, 1'b0, 18'h00123},
    {1'b0, 8'h00, 1'b0, 18'h00000, 1'b1, 8'h90, 1'b0, 18'h00123}, // R4
    {1'b0, 8'h00, 1'b1, 18'h3FFFF, 1'b1, 8'h10, 1'b1, 18'h3FFFF}, // R3 collision
    {1'b0, 8'h00, 1'b1, 18'h00055, 1'b0, 8'h10, 1'b1, 18'h00055}, // R2 unread overwrite
    {1'b1, 8'h00, 1'b0, 18'h00000, 1'b0, 8'h00, 1'b0, 18'h00055}, // R7 R10
    {1'b1, 8'h80, 1'b0, 18'h00000, 1'b0, 8'h80, 1'b1, 18'h00055}, // R6
    {1'b0, 8'h00, 1'b0, 18'h00000, 1'b0, 8'h80, 1'b0, 18'h00055}, // R6 in progress
    {1'b0, 8'h00, 1'b0, 18'h00000, 1'b1, 8'h80, 1'b0, 18'h00055}, // R6 read mid-conv
    {1'b0, 8'h00, 1'b1, 18'h2AAAA, 1'b0, 8'h00, 1'b0, 18'h2AAAA}, // R9 one-shot quiet
    {1'b0, 8'h00, 1'b0, 18'h00000, 1'b1, 8'h00, 1'b0, 18'h2AAAA}, // R5
    {1'b0, 8'h00, 1'b0, 18'h00000, 1'b0, 8'h00, 1'b0, 18'h2AAAA}, // R5
    {1'b1, 8'h00, 1'b0, 18'h00000, 1'b0, 8'h00, 1'b0, 18'h2AAAA}, // R7 repeat
    {1'b1, 8'h7F, 1'b0, 18'h00000, 1'b0, 8'h7F, 1'b1, 18'h2AAAA}, // R8 R10
    {1'b1, 8'h80, 1'b1, 18'h00001, 1'b0, 8'h00, 1'b1, 18'h00001}, // R3 with write
    {1'b0, 8'h00, 1'b1, 18'h00010, 1'b0, 8'h00, 1'b0, 18'h00010}  // R9 one-shot
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic conv_done = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic rd_done = 1'b0;
  logic conv_start;
  logic [RES_W-1:0] result;
  logic [7:0] status;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnv_ready_ctrl #(.RES_W(RES_W)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .conv_done(conv_done), .conv_data(conv_data), .rd_done(rd_done),
    .conv_start(conv_start), .result(result), .status(status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic dn,
                      input logic [RES_W-1:0] dd, input logic rd);
    @(negedge clk);
    cfg_wr = w; cfg_data = d; conv_done = dn; conv_data = dd; rd_done = rd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 status", 32'(status), 32'h90);
    check("R1 result", 32'(result), 32'h0);
    check("R1 conv_start", 32'(conv_start), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[VW-1], v[VW-2 -: 8], v[VW-10], v[VW-11 -: RES_W], v[VW-11-RES_W]);
      check($sformatf("R3/R4/R5/R6/R7/R10 status vec%0d", i),
            32'(status), 32'(v[RES_W+1 +: 8]));
      check($sformatf("R6/R8/R9 conv_start vec%0d", i),
            32'(conv_start), 32'(v[RES_W]));
      check($sformatf("R2 result vec%0d", i),
            32'(result), 32'(v[RES_W-1:0]));
    end

    // R1: reset mid-run, with a completion pending in the same cycle
    @(negedge clk);
    rst = 1'b1; conv_done = 1'b1; conv_data = 18'h12345; cfg_wr = 1'b0; rd_done = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0; conv_done = 1'b0;
    #1;
    check("R1 status after mid reset", 32'(status), 32'h90);
    check("R1 result after mid reset", 32'(result), 32'h0);
    check("R1 conv_start after mid reset", 32'(conv_start), 32'h0);

    // R4: continuous read after reset keeps the flag high
    step(1'b0, 8'h00, 1'b0, '0, 1'b1);
    check("R4 read with no result", 32'(status[7]), 32'h1);
    step(1'b0, 8'h00, 1'b0, '0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule